// File: doc/BRIEF.md
# Calendar Timekeeper with Preset

This block keeps wall-clock time and date in fabric registers: seconds, minutes, hours, day of month, month and year. It holds no oscillator of its own. Its only timing input is a free-running sub-second counter from an always-on domain, and one bit of that counter completes a full cycle once per second. The block brings that bit into its own clock domain through a two-stage synchroniser. Each rising edge of the synchronised bit advances the calendar by exactly one second.

A host can load a complete time and date on any clock cycle through the preset port. The load writes only the block's own time registers and never touches the external counter. Counting then carries on from the loaded value at the next seconds tick. A load that carries any out-of-range field is discarded, and an error flag is raised for one cycle.

Top module: `caltime_keeper`

## Requirements
- R1: While reset is asserted, and after it is released until the first event, the outputs read 00:00:00, day 1, month 1, year 0, with `load_err` low.
- R2: A low-to-high change of `subsec_cnt[TICK_BIT]` advances the time by one second. The new value appears after the third rising clock edge that samples the bit high, counting the first such edge. Holding the bit high, or its falling edge, causes no further advance.
- R3: Seconds count 0..59 and minutes count 0..59, each wrapping to 0 and carrying into the next field. Hours count 0..23 and wrap to 0, carrying into the day.
- R4: The day runs from 1 up to the month length and then wraps to 1, carrying into the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the two low bits of the year are 00, and 28 days otherwise. All other months have 31 days.
- R5: Month 12 wraps to month 1 and increments the year. The year wraps from 2**YEAR_W-1 to 0.
- R6: When `load_en` is high and every load field is in range, all six fields take the load values at that clock edge. Later ticks advance from the loaded value.
- R7: When `load_en` is high in the same cycle as a tick, the load is applied and that tick is lost; the time is not advanced for it.
- R8: When `load_en` is high and any load field is out of range, the time is left unchanged. `load_err` is then high for exactly the one cycle after that edge. Out of range means: seconds or minutes above 59, hours above 23, month 0 or above 12, day 0, or day above the length of the given month in the given year.
- R9: Bits of `subsec_cnt` other than bit `TICK_BIT` have no effect on the time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| subsec_cnt | input | SUBSEC_W | Free-running sub-second counter from the always-on domain |
| load_en | input | 1 | Preset strobe, one cycle per load |
| load_sec | input | 6 | Seconds value to load |
| load_min | input | 6 | Minutes value to load |
| load_hour | input | 5 | Hours value to load |
| load_day | input | 5 | Day of month to load |
| load_mon | input | 4 | Month to load (1..12) |
| load_year | input | YEAR_W | Year to load |
| time_sec | output | 6 | Current seconds |
| time_min | output | 6 | Current minutes |
| time_hour | output | 5 | Current hours |
| time_day | output | 5 | Current day of month |
| time_mon | output | 4 | Current month |
| time_year | output | YEAR_W | Current year |
| load_err | output | 1 | One-cycle flag for a rejected preset |

## Verification
The counting path is tried with three kinds of pulse on the tick bit. Short pulses show the synchroniser latency. Long high pulses show that a level causes only one advance and is not counted again. Pulses with the other counter bits scrambled on every cycle show that only the chosen bit is decoded. Presets just below each rollover point separate the carry chain cases from one another: end of a 30-day month, 31-day month, February in leap and non-leap years, December into a new year, and the top year into year 0. A preset placed in the exact cycle of a tick separates the intended drop of that tick from a design that applies both. A set of out-of-range presets, one for each field, shows that every limit is checked, including a day that is legal in one month and illegal in another.

// File: rtl/caltime_pkg.sv
package caltime_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int MON_LAST  = 12;

    typedef logic [SEC_W-1:0]  sec_t;
    typedef logic [MIN_W-1:0]  min_t;
    typedef logic [HOUR_W-1:0] hour_t;
    typedef logic [DAY_W-1:0]  day_t;
    typedef logic [MON_W-1:0]  mon_t;
endpackage

// File: rtl/cal_month_len.sv
// Days in a month; February depends on the leap flag (R4).
module cal_month_len
    import caltime_pkg::*;
(
    input  mon_t mon_i,
    input  logic leap_i,
    output day_t len_o
);
    always_comb begin
        case (mon_i)
            MON_W'(2):  len_o = leap_i ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4),
            MON_W'(6),
            MON_W'(9),
            MON_W'(11): len_o = DAY_W'(30);
            default:    len_o = DAY_W'(31);
        endcase
    end
endmodule

// File: rtl/cal_tick_gen.sv
// Two-stage synchroniser plus rising-edge detect on one counter bit (R2, R9).
module cal_tick_gen #(
    parameter int CNT_W    = 15,
    parameter int TICK_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             tick_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    // Only bit TICK_BIT matters; the rest is folded away here (R9).
    logic unused_cnt_bits;
    assign unused_cnt_bits = ^cnt_i;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = cnt_i[TICK_BIT];
        sync_d.sync = sync_q.meta;
        sync_d.prev = sync_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign tick_o = sync_q.sync & ~sync_q.prev;
endmodule

// File: rtl/cal_range_chk.sv
// Accepts a preset only when every field is within its calendar range (R8).
module cal_range_chk
    import caltime_pkg::*;
#(
    parameter int YEAR_W = 12
) (
    input  sec_t              sec_i,
    input  min_t              min_i,
    input  hour_t             hour_i,
    input  day_t              day_i,
    input  mon_t              mon_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic              ok_o
);
    day_t len;
    logic leap;

    assign leap = (year_i[1:0] == 2'b00);

    cal_month_len u_len (
        .mon_i  (mon_i),
        .leap_i (leap),
        .len_o  (len)
    );

    always_comb begin
        ok_o = (sec_i  <= SEC_W'(SEC_LAST))
            && (min_i  <= MIN_W'(MIN_LAST))
            && (hour_i <= HOUR_W'(HOUR_LAST))
            && (mon_i  != '0)
            && (mon_i  <= MON_W'(MON_LAST))
            && (day_i  != '0)
            && (day_i  <= len);
    end
endmodule

// File: rtl/caltime_keeper.sv
module caltime_keeper
    import caltime_pkg::*;
#(
    parameter int SUBSEC_W = 15,
    parameter int TICK_BIT = 7,
    parameter int YEAR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SUBSEC_W-1:0] subsec_cnt,
    input  logic                load_en,
    input  logic [5:0]          load_sec,
    input  logic [5:0]          load_min,
    input  logic [4:0]          load_hour,
    input  logic [4:0]          load_day,
    input  logic [3:0]          load_mon,
    input  logic [YEAR_W-1:0]   load_year,
    output logic [5:0]          time_sec,
    output logic [5:0]          time_min,
    output logic [4:0]          time_hour,
    output logic [4:0]          time_day,
    output logic [3:0]          time_mon,
    output logic [YEAR_W-1:0]   time_year,
    output logic                load_err
);
    typedef struct packed {
        sec_t              sec;
        min_t              mn;
        hour_t             hr;
        day_t              dy;
        mon_t              mo;
        logic [YEAR_W-1:0] yr;
        logic              err;
    } st_t;

    st_t  st_d, st_q;
    logic tick;
    logic load_ok;
    day_t cur_len;
    logic cur_leap;

    cal_tick_gen #(
        .CNT_W    (SUBSEC_W),
        .TICK_BIT (TICK_BIT)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (subsec_cnt),
        .tick_o (tick)
    );

    cal_range_chk #(
        .YEAR_W (YEAR_W)
    ) u_chk_in (
        .sec_i  (load_sec),
        .min_i  (load_min),
        .hour_i (load_hour),
        .day_i  (load_day),
        .mon_i  (load_mon),
        .year_i (load_year),
        .ok_o   (load_ok)
    );

    assign cur_leap = (st_q.yr[1:0] == 2'b00);

    cal_month_len u_cur_len (
        .mon_i  (st_q.mo),
        .leap_i (cur_leap),
        .len_o  (cur_len)
    );

    // Load takes priority over a tick in the same cycle (R6, R7, R8);
    // a tick walks the carry chain (R3, R4, R5).
    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (load_en) begin
            if (load_ok) begin
                st_d.sec = load_sec;
                st_d.mn  = load_min;
                st_d.hr  = load_hour;
                st_d.dy  = load_day;
                st_d.mo  = load_mon;
                st_d.yr  = load_year;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (tick) begin
            if (st_q.sec != SEC_W'(SEC_LAST)) begin
                st_d.sec = st_q.sec + 1'b1;
            end else begin
                st_d.sec = '0;
                if (st_q.mn != MIN_W'(MIN_LAST)) begin
                    st_d.mn = st_q.mn + 1'b1;
                end else begin
                    st_d.mn = '0;
                    if (st_q.hr != HOUR_W'(HOUR_LAST)) begin
                        st_d.hr = st_q.hr + 1'b1;
                    end else begin
                        st_d.hr = '0;
                        if (st_q.dy < cur_len) begin
                            st_d.dy = st_q.dy + 1'b1;
                        end else begin
                            st_d.dy = DAY_W'(1);
                            if (st_q.mo < MON_W'(MON_LAST)) begin
                                st_d.mo = st_q.mo + 1'b1;
                            end else begin
                                st_d.mo = MON_W'(1);
                                st_d.yr = st_q.yr + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    // R1: reset to 00:00:00 on day 1 of month 1, year 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.dy <= DAY_W'(1);
            st_q.mo <= MON_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign time_sec  = st_q.sec;
    assign time_min  = st_q.mn;
    assign time_hour = st_q.hr;
    assign time_day  = st_q.dy;
    assign time_mon  = st_q.mo;
    assign time_year = st_q.yr;
    assign load_err  = st_q.err;
endmodule

// File: rtl/caltime_keeper_chk.sv
module caltime_keeper_chk #(
    parameter int YEAR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              load_en,
    input logic [5:0]        load_sec,
    input logic [5:0]        load_min,
    input logic [4:0]        load_hour,
    input logic [4:0]        load_day,
    input logic [3:0]        load_mon,
    input logic [YEAR_W-1:0] load_year,
    input logic [5:0]        time_sec,
    input logic [5:0]        time_min,
    input logic [4:0]        time_hour,
    input logic [4:0]        time_day,
    input logic [3:0]        time_mon,
    input logic [YEAR_W-1:0] time_year,
    input logic              load_err
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (time_sec == 6'd0 && time_min == 6'd0 && time_hour == 5'd0
                    && time_day == 5'd1 && time_mon == 4'd1 && time_year == '0 && !load_err));

    a_r3_clock_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        time_sec <= 6'd59 && time_min <= 6'd59 && time_hour <= 5'd23);

    a_r4_date_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        time_day >= 5'd1 && time_day <= 5'd31 && time_mon >= 4'd1 && time_mon <= 4'd12);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !tick) |=> ($stable(time_sec) && $stable(time_min) && $stable(time_hour)
                                 && $stable(time_day) && $stable(time_mon) && $stable(time_year)));

    a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=>
            (time_sec == (($past(time_sec) == 6'd59) ? 6'd0 : 6'($past(time_sec) + 6'd1))));

    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (load_err || (time_sec == $past(load_sec) && time_min == $past(load_min)
                     && time_hour == $past(load_hour) && time_day == $past(load_day)
                     && time_mon == $past(load_mon) && time_year == $past(load_year))));

    a_r7_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && tick) |=> (load_err || time_sec == $past(load_sec)));

    a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> $past(load_en));

    a_r8_err_keeps_time: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> ($stable(time_sec) && $stable(time_min) && $stable(time_hour)
                      && $stable(time_day) && $stable(time_mon) && $stable(time_year)));
endmodule

bind caltime_keeper caltime_keeper_chk #(.YEAR_W(YEAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_en   (load_en),
    .load_sec  (load_sec),
    .load_min  (load_min),
    .load_hour (load_hour),
    .load_day  (load_day),
    .load_mon  (load_mon),
    .load_year (load_year),
    .time_sec  (time_sec),
    .time_min  (time_min),
    .time_hour (time_hour),
    .time_day  (time_day),
    .time_mon  (time_mon),
    .time_year (time_year),
    .load_err  (load_err)
);

// File: tb/caltime_keeper_tb.sv
`timescale 1ns/1ps
module caltime_keeper_tb;
    localparam int SUBSEC_W = 15;
    localparam int TICK_BIT = 7;
    localparam int YEAR_W   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SUBSEC_W-1:0] subsec = '0;
    logic load_en = 1'b0;
    logic [5:0] l_sec = '0, l_min = '0;
    logic [4:0] l_hour = '0, l_day = '0;
    logic [3:0] l_mon = '0;
    logic [YEAR_W-1:0] l_year = '0;
    logic [5:0] o_sec, o_min;
    logic [4:0] o_hour, o_day;
    logic [3:0] o_mon;
    logic [YEAR_W-1:0] o_year;
    logic o_err;

    always #2 clk = ~clk;

    caltime_keeper #(.SUBSEC_W(SUBSEC_W), .TICK_BIT(TICK_BIT), .YEAR_W(YEAR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .subsec_cnt(subsec), .load_en(load_en),
        .load_sec(l_sec), .load_min(l_min), .load_hour(l_hour), .load_day(l_day),
        .load_mon(l_mon), .load_year(l_year),
        .time_sec(o_sec), .time_min(o_min), .time_hour(o_hour), .time_day(o_day),
        .time_mon(o_mon), .time_year(o_year), .load_err(o_err));

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string phase = "R1";

    // behavioural reference
    int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_err;
    int p1, p2, p3;
    bit m_tick;

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit fields_ok(int s, int mi, int h, int d, int mo, int yr);
        return s < 60 && mi < 60 && h < 24 && mo >= 1 && mo <= 12 && d >= 1 && d <= mlen(mo, yr);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0; m_err = 0;
            p1 = 0; p2 = 0; p3 = 0;
        end else begin
            started = 1'b1;
            m_tick = (p2 == 1) && (p3 == 0);
            p3 = p2; p2 = p1; p1 = int'(subsec[TICK_BIT]);
            m_err = 0;
            if (load_en) begin
                if (fields_ok(l_sec, l_min, l_hour, l_day, l_mon, l_year)) begin
                    m_sec = l_sec; m_min = l_min; m_hour = l_hour;
                    m_day = l_day; m_mon = l_mon; m_year = l_year;
                end else begin
                    m_err = 1;
                end
            end else if (m_tick) begin
                m_sec++;
                if (m_sec == 60) begin m_sec = 0; m_min++; end
                if (m_min == 60) begin m_min = 0; m_hour++; end
                if (m_hour == 24) begin m_hour = 0; m_day++; end
                if (m_day > mlen(m_mon, m_year)) begin m_day = 1; m_mon++; end
                if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % (1 << YEAR_W); end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (int'(o_sec) != m_sec || int'(o_min) != m_min || int'(o_hour) != m_hour ||
                int'(o_day) != m_day || int'(o_mon) != m_mon || int'(o_year) != m_year ||
                int'(o_err) != m_err) begin
                bad++;
                $display("FAIL %s model: got %0d-%0d-%0d %0d:%0d:%0d err=%0d exp %0d-%0d-%0d %0d:%0d:%0d err=%0d",
                         phase, o_year, o_mon, o_day, o_hour, o_min, o_sec, o_err,
                         m_year, m_mon, m_day, m_hour, m_min, m_sec, m_err);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(bit b);
        subsec = SUBSEC_W'($urandom);
        subsec[TICK_BIT] = b;
    endtask

    task automatic tick_pulse(int hi, int lo);
        for (int i = 0; i < hi; i++) begin @(negedge clk); drive_bit(1'b1); end
        for (int i = 0; i < lo; i++) begin @(negedge clk); drive_bit(1'b0); end
    endtask

    task automatic set_load(int s, int mi, int h, int d, int mo, int yr);
        l_sec = 6'(s); l_min = 6'(mi); l_hour = 5'(h);
        l_day = 5'(d); l_mon = 4'(mo); l_year = YEAR_W'(yr);
    endtask

    task automatic preset(int s, int mi, int h, int d, int mo, int yr);
        @(negedge clk);
        set_load(s, mi, h, d, mo, yr);
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic expect_t(string req, int s, int mi, int h, int d, int mo, int yr);
        total++;
        if (int'(o_sec) != s || int'(o_min) != mi || int'(o_hour) != h ||
            int'(o_day) != d || int'(o_mon) != mo || int'(o_year) != yr) begin
            bad++;
            $display("FAIL %s: got %0d-%0d-%0d %0d:%0d:%0d exp %0d-%0d-%0d %0d:%0d:%0d",
                     req, o_year, o_mon, o_day, o_hour, o_min, o_sec, yr, mo, d, h, mi, s);
        end
    endtask

    task automatic expect_err(string req, bit e);
        total++;
        if (o_err != e) begin
            bad++;
            $display("FAIL %s: load_err got %0d exp %0d", req, o_err, e);
        end
    endtask

    task automatic bad_preset(int s, int mi, int h, int d, int mo, int yr);
        preset(s, mi, h, d, mo, yr);
        expect_err("R8", 1'b1);
        expect_t("R8", 30, 20, 10, 15, 6, 2023);
        cyc(1);
        expect_err("R8", 1'b0);
    endtask

    initial begin
        // R1: reset values
        cyc(3);
        expect_t("R1", 0, 0, 0, 1, 1, 0);
        expect_err("R1", 1'b0);
        rst_n = 1'b1;
        cyc(4);
        expect_t("R1", 0, 0, 0, 1, 1, 0);

        // R2: latency of one short pulse
        phase = "R2";
        @(negedge clk); drive_bit(1'b1);
        @(negedge clk); drive_bit(1'b0);
        @(negedge clk);
        expect_t("R2", 0, 0, 0, 1, 1, 0);
        @(negedge clk);
        expect_t("R2", 1, 0, 0, 1, 1, 0);
        cyc(4);
        // R2: a long high level counts once
        tick_pulse(40, 6);
        expect_t("R2", 2, 0, 0, 1, 1, 0);

        // R9: other bits scrambled while tick bit stays low
        phase = "R9";
        for (int i = 0; i < 50; i++) begin @(negedge clk); drive_bit(1'b0); end
        expect_t("R9", 2, 0, 0, 1, 1, 0);
        for (int i = 0; i < 5; i++) tick_pulse(3, 3);
        expect_t("R9", 7, 0, 0, 1, 1, 0);

        // R6: preset then counting resumes; R3/R5 carries into a new year
        phase = "R6";
        preset(58, 59, 23, 31, 12, 2023);
        expect_t("R6", 58, 59, 23, 31, 12, 2023);
        tick_pulse(2, 4);
        expect_t("R6", 59, 59, 23, 31, 12, 2023);
        phase = "R5";
        tick_pulse(2, 4);
        expect_t("R5", 0, 0, 0, 1, 1, 2024);

        // R3: minute and hour carries
        phase = "R3";
        preset(59, 14, 7, 3, 3, 100);
        tick_pulse(2, 4);
        expect_t("R3", 0, 15, 7, 3, 3, 100);
        preset(59, 59, 7, 3, 3, 100);
        tick_pulse(2, 4);
        expect_t("R3", 0, 0, 8, 3, 3, 100);

        // R4: month lengths and leap February
        phase = "R4";
        preset(59, 59, 23, 28, 2, 2024);
        tick_pulse(2, 4);
        expect_t("R4", 0, 0, 0, 29, 2, 2024);
        preset(59, 59, 23, 29, 2, 2024);
        tick_pulse(2, 4);
        expect_t("R4", 0, 0, 0, 1, 3, 2024);
        preset(59, 59, 23, 28, 2, 2023);
        tick_pulse(2, 4);
        expect_t("R4", 0, 0, 0, 1, 3, 2023);
        preset(59, 59, 23, 30, 4, 2023);
        tick_pulse(2, 4);
        expect_t("R4", 0, 0, 0, 1, 5, 2023);
        preset(59, 59, 23, 30, 1, 2023);
        tick_pulse(2, 4);
        expect_t("R4", 0, 0, 0, 31, 1, 2023);
        tick_pulse(1, 5);
        tick_pulse(1, 5);
        expect_t("R4", 2, 0, 0, 31, 1, 2023);

        // R5: top year wraps to 0
        phase = "R5";
        preset(59, 59, 23, 31, 12, (1 << YEAR_W) - 1);
        tick_pulse(2, 4);
        expect_t("R5", 0, 0, 0, 1, 1, 0);

        // R7: preset in the tick cycle wins
        phase = "R7";
        cyc(4);
        @(negedge clk); drive_bit(1'b1);
        @(negedge clk); drive_bit(1'b1);
        @(negedge clk); drive_bit(1'b1);
        set_load(10, 11, 12, 13, 7, 2030);
        load_en = 1'b1;
        @(negedge clk); load_en = 1'b0; drive_bit(1'b0);
        expect_t("R7", 10, 11, 12, 13, 7, 2030);
        cyc(6);
        expect_t("R7", 10, 11, 12, 13, 7, 2030);

        // R8: each out-of-range field is rejected
        phase = "R8";
        preset(30, 20, 10, 15, 6, 2023);
        bad_preset(60, 0, 0, 1, 1, 2023);
        bad_preset(0, 60, 0, 1, 1, 2023);
        bad_preset(0, 0, 24, 1, 1, 2023);
        bad_preset(0, 0, 0, 0, 1, 2023);
        bad_preset(0, 0, 0, 1, 0, 2023);
        bad_preset(0, 0, 0, 1, 13, 2023);
        bad_preset(0, 0, 0, 31, 4, 2023);
        bad_preset(0, 0, 0, 29, 2, 2023);
        tick_pulse(2, 4);
        expect_t("R8", 31, 20, 10, 15, 6, 2023);
        expect_err("R8", 1'b0);

        cyc(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule